// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Checker

This block watches the command bus of a double-data-rate SDRAM, as a device model or a protocol monitor would. On every rising clock edge it samples chip select, the three strobes (row, column, write), clock enable, the two bank bits and the 13-bit address. It reduces each cycle to exactly one command and presents that command as a one-hot vector. Alongside it presents the bank, the row or opcode, the column with bit 10 removed, the auto-precharge and all-banks flags, and which mode register is the target.

The block keeps a small burst tracker that records the kind of the most recent read or write burst. It uses the tracker to judge whether a burst-terminate command is legal. It also flags a reserved mode-register target and any command other than refresh that is issued while clock enable is low. Errors appear as a per-cycle cause vector and as a sticky flag that only reset clears. The data-mask pin is turned straight into a write-beat qualifier.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: With chip select low, strobes row/column/write give the command: 0/1/1 activate, 1/0/1 read, 1/0/0 write, 1/1/0 burst terminate, 0/1/0 precharge, 0/0/1 refresh, 0/0/0 load mode. The one-hot `cmd_valid` bit indices are: 0 no-op, 1 activate, 2 read, 3 write, 4 burst terminate, 5 precharge, 6 auto refresh, 7 self refresh, 8 load mode. A high chip select and 1/1/1 both give index 0.
- R2: Every decoded output is registered. It reflects the bus sampled at the previous rising edge, and exactly one `cmd_valid` bit is set at any time.
- R3: On a read or write, `cmd_autopre` equals address bit 10. It is 0 for every other command.
- R4: On a precharge, `cmd_all_banks` equals address bit 10 and `cmd_bank` carries the bank bits. It is 0 for every other command.
- R5: The refresh encoding decodes as auto refresh (index 6) when clock enable is high, and as self refresh (index 7) when it is low.
- R6: Any command other than no-op and refresh that is sampled with clock enable low decodes as no-op (index 0) and sets `err_cause` bit 2.
- R7: On load mode, `cmd_row` carries address bits 12..0 as the opcode. `cmd_ext_mode` is 1 for bank bits 01. Bank bits with bit 1 high set `err_cause` bit 1.
- R8: A burst terminate is legal only within BURST_CYCLES command slots after a read without auto-precharge. Otherwise, including after a write or a read with auto-precharge, it sets `err_cause` bit 0.
- R9: The burst tracker is replaced by each new read or write, and cleared by any burst terminate or precharge.
- R10: `cmd_col` bits 9..0 are address bits 9..0. Bit 10 is address bit 11 for x4/x8 organisation and 0 for x16. Bit 11 is address bit 12 for x4 only and 0 otherwise.
- R11: `wr_beat_en` is the inverse of `dm`, with no register in between.
- R12: Reset sets `cmd_valid` to no-op and clears `err_cause` and `err_sticky`. `err_sticky` rises one cycle after any error cause and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank bits |
| addr | input | 13 | Address bus |
| dm | input | 1 | Data mask for the current write beat |
| wr_beat_en | output | 1 | Beat write qualifier, high when the beat is written |
| cmd_valid | output | 9 | One-hot decoded command |
| cmd_bank | output | 2 | Registered bank bits |
| cmd_row | output | 13 | Registered row address or mode opcode |
| cmd_col | output | 12 | Registered column, bit 10 removed, unused bits zero |
| cmd_autopre | output | 1 | Auto-precharge requested by this burst |
| cmd_all_banks | output | 1 | Precharge applies to all banks |
| cmd_ext_mode | output | 1 | Load mode targets the extended register |
| err_cause | output | 3 | Per-cycle cause: bit0 terminate, bit1 mode target, bit2 clock enable |
| err_sticky | output | 1 | Latched error since reset |

## Verification
The command vector, fields and error cause are all due exactly one rising edge after the bus is sampled. The sticky flag follows the error cause one edge later, and the beat qualifier is due at once. The bench drives each command on a falling edge and checks on the next falling edge. So it always reads the result of the single rising edge in between, and it reads the sticky flag only after a further idle cycle. Burst-terminate legality depends on how many slots have passed since the read, so the bench places terminates at the last legal slot and at the first illegal one.

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder #(
  parameter int ORG          = 8,
  parameter int BURST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cke,
  input  logic        cs_n,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic [1:0]  ba,
  input  logic [12:0] addr,
  input  logic        dm,
  output logic        wr_beat_en,
  output logic [8:0]  cmd_valid,
  output logic [1:0]  cmd_bank,
  output logic [12:0] cmd_row,
  output logic [11:0] cmd_col,
  output logic        cmd_autopre,
  output logic        cmd_all_banks,
  output logic        cmd_ext_mode,
  output logic [2:0]  err_cause,
  output logic        err_sticky
);
  localparam int CNT_W = $clog2(BURST_CYCLES + 1);
  localparam logic [3:0] C_NOP = 4'd0, C_ACT = 4'd1, C_RD = 4'd2, C_WR = 4'd3,
                         C_BST = 4'd4, C_PRE = 4'd5, C_AREF = 4'd6,
                         C_SREF = 4'd7, C_LMR = 4'd8;

  logic [3:0]       idx;
  logic             cke_bad;
  logic [CNT_W-1:0] burst_left;
  logic             burst_rd, burst_ap;
  logic [11:0]      col_n;

  assign wr_beat_en = ~dm;

  always_comb begin
    idx     = C_NOP;
    cke_bad = 1'b0;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  idx = C_ACT;
        3'b101:  idx = C_RD;
        3'b100:  idx = C_WR;
        3'b110:  idx = C_BST;
        3'b010:  idx = C_PRE;
        3'b001:  idx = cke ? C_AREF : C_SREF;
        3'b000:  idx = C_LMR;
        default: idx = C_NOP;
      endcase
    end
    if (!cke && idx != C_NOP && idx != C_SREF) begin
      cke_bad = 1'b1;
      idx     = C_NOP;
    end
  end

  wire is_burst  = (idx == C_RD) || (idx == C_WR);
  wire bst_legal = (burst_left != '0) && burst_rd && !burst_ap;
  wire [2:0] err_n = {cke_bad,
                      (idx == C_LMR) && ba[1],
                      (idx == C_BST) && !bst_legal};

  always_comb begin
    col_n      = '0;
    col_n[9:0] = addr[9:0];
    if (ORG <= 8) col_n[10] = addr[11];
    if (ORG == 4) col_n[11] = addr[12];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid     <= 9'd1;
      cmd_bank      <= '0;
      cmd_row       <= '0;
      cmd_col       <= '0;
      cmd_autopre   <= 1'b0;
      cmd_all_banks <= 1'b0;
      cmd_ext_mode  <= 1'b0;
      err_cause     <= '0;
      err_sticky    <= 1'b0;
      burst_left    <= '0;
      burst_rd      <= 1'b0;
      burst_ap      <= 1'b0;
    end else begin
      cmd_valid     <= 9'd1 << idx;
      cmd_bank      <= ba;
      cmd_row       <= addr;
      cmd_col       <= col_n;
      cmd_autopre   <= is_burst && addr[10];
      cmd_all_banks <= (idx == C_PRE) && addr[10];
      cmd_ext_mode  <= (idx == C_LMR) && (ba == 2'b01);
      err_cause     <= err_n;
      err_sticky    <= err_sticky | (|err_cause);
      if (is_burst) begin
        burst_left <= CNT_W'(BURST_CYCLES);
        burst_rd   <= (idx == C_RD);
        burst_ap   <= addr[10];
      end else if (idx == C_BST || idx == C_PRE) begin
        burst_left <= '0;
      end else if (burst_left != '0) begin
        burst_left <= burst_left - 1'b1;
      end
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmd_valid) == 1);
  p_autopre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && ras_n && !cas_n && addr[10]) |=> cmd_autopre);
  p_cke_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !cs_n && {ras_n, cas_n, we_n} != 3'b111 && {ras_n, cas_n, we_n} != 3'b001)
    |=> (err_cause[2] && cmd_valid[0]));
  p_bst_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && ras_n && cas_n && !we_n && burst_left == '0) |=> err_cause[0]);
  p_pre_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && !ras_n && cas_n && !we_n) |=> (burst_left == '0));
  p_col_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ORG != 4) |-> (cmd_col[11] == 1'b0));
  p_sticky_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
endmodule

// File: tb/ddr_cmd_decoder_test.sv
`timescale 1ns/1ps
module ddr_cmd_decoder_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dm = 1'b0;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic wr_beat_en, cmd_autopre, cmd_all_banks, cmd_ext_mode, err_sticky;
  logic [8:0] cmd_valid;
  logic [1:0] cmd_bank;
  logic [12:0] cmd_row;
  logic [11:0] cmd_col;
  logic [2:0] err_cause;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ddr_cmd_decoder #(.ORG(8), .BURST_CYCLES(4)) uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dm(dm), .wr_beat_en(wr_beat_en),
    .cmd_valid(cmd_valid), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .cmd_autopre(cmd_autopre), .cmd_all_banks(cmd_all_banks), .cmd_ext_mode(cmd_ext_mode),
    .err_cause(err_cause), .err_sticky(err_sticky));

  typedef struct packed {
    logic        cke;
    logic        cs;
    logic [2:0]  rcw;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [3:0]  idx;
    logic [2:0]  err;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 3'b111, 2'd0, 13'h0000, 4'd0, 3'b000},
    '{1'b1, 1'b0, 3'b111, 2'd0, 13'h0000, 4'd0, 3'b000},
    '{1'b1, 1'b0, 3'b011, 2'd2, 13'h1ABC, 4'd1, 3'b000},
    '{1'b1, 1'b0, 3'b101, 2'd1, 13'h0455, 4'd2, 3'b000},
    '{1'b1, 1'b0, 3'b110, 2'd0, 13'h0000, 4'd4, 3'b001},
    '{1'b1, 1'b0, 3'b101, 2'd1, 13'h0055, 4'd2, 3'b000},
    '{1'b1, 1'b0, 3'b111, 2'd0, 13'h0000, 4'd0, 3'b000},
    '{1'b1, 1'b0, 3'b110, 2'd0, 13'h0000, 4'd4, 3'b000},
    '{1'b1, 1'b0, 3'b110, 2'd0, 13'h0000, 4'd4, 3'b001},
    '{1'b1, 1'b0, 3'b100, 2'd3, 13'h0012, 4'd3, 3'b000},
    '{1'b1, 1'b0, 3'b110, 2'd0, 13'h0000, 4'd4, 3'b001},
    '{1'b1, 1'b0, 3'b010, 2'd0, 13'h0400, 4'd5, 3'b000},
    '{1'b1, 1'b0, 3'b001, 2'd0, 13'h0000, 4'd6, 3'b000},
    '{1'b0, 1'b0, 3'b001, 2'd0, 13'h0000, 4'd7, 3'b000},
    '{1'b0, 1'b0, 3'b011, 2'd0, 13'h0001, 4'd0, 3'b100},
    '{1'b1, 1'b0, 3'b000, 2'd0, 13'h0032, 4'd8, 3'b000},
    '{1'b1, 1'b0, 3'b000, 2'd1, 13'h0040, 4'd8, 3'b000},
    '{1'b1, 1'b0, 3'b000, 2'd2, 13'h0000, 4'd8, 3'b010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic k, input logic c, input logic [2:0] rcw,
                       input logic [1:0] b, input logic [12:0] a);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a;
    @(negedge clk);
  endtask

  task automatic nop();
    issue(1'b1, 1'b0, 3'b111, 2'd0, 13'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    nop();
    nop();
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    chk("R12 reset cmd_valid", 32'(cmd_valid), 32'h1);
    chk("R12 reset err_cause", 32'(err_cause), 32'h0);
    chk("R12 reset err_sticky", 32'(err_sticky), 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].cke, VECS[i].cs, VECS[i].rcw, VECS[i].ba, VECS[i].addr);
      chk($sformatf("R1/R2 vector %0d cmd_valid", i), 32'(cmd_valid), 32'(9'd1 << VECS[i].idx));
      chk($sformatf("R5/R6/R7/R8 vector %0d err_cause", i), 32'(err_cause), 32'(VECS[i].err));
    end

    nop();
    nop();
    chk("R12 sticky holds after errors", 32'(err_sticky), 32'h1);
    do_reset();
    chk("R12 sticky cleared by reset", 32'(err_sticky), 32'h0);

    issue(1'b1, 1'b0, 3'b101, 2'd2, 13'h1A53);
    chk("R10 column x8 mapping", 32'(cmd_col), 32'h653);
    chk("R3 autopre low", 32'(cmd_autopre), 32'h0);
    issue(1'b1, 1'b0, 3'b100, 2'd0, 13'h0400);
    chk("R3 autopre high on write", 32'(cmd_autopre), 32'h1);
    chk("R10 bit 10 excluded", 32'(cmd_col), 32'h0);
    issue(1'b1, 1'b0, 3'b011, 2'd0, 13'h0400);
    chk("R3 autopre zero on activate", 32'(cmd_autopre), 32'h0);
    issue(1'b1, 1'b0, 3'b010, 2'd3, 13'h0000);
    chk("R4 single bank precharge", 32'(cmd_all_banks), 32'h0);
    chk("R4 precharge bank", 32'(cmd_bank), 32'h3);
    issue(1'b1, 1'b0, 3'b010, 2'd1, 13'h0400);
    chk("R4 all banks precharge", 32'(cmd_all_banks), 32'h1);
    issue(1'b1, 1'b0, 3'b011, 2'd2, 13'h1ABC);
    chk("R1 activate row", 32'(cmd_row), 32'h1ABC);
    chk("R1 activate bank", 32'(cmd_bank), 32'h2);
    chk("R4 all banks zero off precharge", 32'(cmd_all_banks), 32'h0);
    issue(1'b1, 1'b0, 3'b000, 2'd1, 13'h1234);
    chk("R7 extended target", 32'(cmd_ext_mode), 32'h1);
    chk("R7 opcode", 32'(cmd_row), 32'h1234);
    issue(1'b1, 1'b0, 3'b000, 2'd0, 13'h0021);
    chk("R7 base target", 32'(cmd_ext_mode), 32'h0);

    issue(1'b1, 1'b0, 3'b101, 2'd0, 13'h0000);
    nop(); nop(); nop();
    issue(1'b1, 1'b0, 3'b110, 2'd0, 13'h0);
    chk("R8 terminate at last legal slot", 32'(err_cause), 32'h0);
    issue(1'b1, 1'b0, 3'b101, 2'd0, 13'h0000);
    nop(); nop(); nop(); nop();
    issue(1'b1, 1'b0, 3'b110, 2'd0, 13'h0);
    chk("R8 terminate after burst ended", 32'(err_cause), 32'h1);
    issue(1'b1, 1'b0, 3'b100, 2'd0, 13'h0000);
    issue(1'b1, 1'b0, 3'b101, 2'd0, 13'h0000);
    issue(1'b1, 1'b0, 3'b110, 2'd0, 13'h0);
    chk("R9 read replaces write burst", 32'(err_cause), 32'h0);
    issue(1'b1, 1'b0, 3'b101, 2'd0, 13'h0000);
    issue(1'b1, 1'b0, 3'b010, 2'd0, 13'h0000);
    issue(1'b1, 1'b0, 3'b110, 2'd0, 13'h0);
    chk("R9 precharge clears burst", 32'(err_cause), 32'h1);
    nop();
    chk("R12 sticky rises after error", 32'(err_sticky), 32'h1);

    dm = 1'b1; #1;
    chk("R11 mask high inhibits", 32'(wr_beat_en), 32'h0);
    dm = 1'b0; #1;
    chk("R11 mask low enables", 32'(wr_beat_en), 32'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule